// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block is a hardware state machine that runs the command sequence a DDR or DDR2 SDRAM needs after power-up, once clock enable is already stable. A start pulse launches it from idle. It then issues six commands in a fixed order: an extended-mode-register write, a mode-register write that resets the DLL, a precharge-all, two auto-refreshes, and a final mode-register write that leaves the DLL alone. Between commands it drives NOP for a programmable number of cycles.

The memory type, the CAS-latency code and the three gap lengths (mode-register-set gap, precharge gap, refresh gap) are captured from the inputs on the start pulse. A CAS-latency code that does not suit the selected memory type does not stop the early steps. It does, however, replace the final mode-register write with an error flag. A controller holds off normal traffic until `done_o` is high.

Top module: `ddr_init_seq`

## Requirements
- R1: During and after reset, with no start pulse, `cmd_o` is NOP and `ba_o`, `addr_o`, `done_o` and `err_o` are all 0. The command codes are NOP=00, PRE (precharge-all)=01, REF (auto-refresh)=10, MRS (mode-register set)=11.
- R2: After an accepted start the commands appear in this order: MRS to the extended register, MRS with DLL reset, PRE, REF, REF, final MRS. Every other cycle shows NOP, and during NOP `ba_o` and `addr_o` are 0.
- R3: The extended-register write drives `ba_o`=01 and `addr_o`=0. This enables the DLL (A0=0).
- R4: The DLL-reset write drives `ba_o`=00 and sets `addr_o` as follows: A12..A9=0, A8:A7=10, A6:A4 equal to the captured CAS code, A3=0 (sequential burst), A2:A0=010 (burst of 4).
- R5: The final write has the same fields as R4 except A8:A7=00. `done_o` rises in the same cycle as this command.
- R6: The first command appears in the cycle after the start edge. Each later command follows the previous one by W cycles. W is the captured mode-register-set gap after each of the two MRS commands, the precharge gap after PRE, and the refresh gap after each REF. A programmed gap of 0 acts as 1.
- R7: The legal CAS codes are 010 and 110 with the DDR1 select (`ddr2_sel_i`=0), and 011 and 100 with the DDR2 select. Any other pairing makes `err_o` rise, with NOP on `cmd_o`, in the cycle where the final MRS would have appeared. No final MRS is issued and `done_o` stays 0.
- R8: PRE drives `ba_o`=00 with only A10 set in `addr_o`. REF drives `ba_o`=00 and `addr_o`=0.
- R9: A start pulse that arrives while a sequence is in progress is ignored.
- R10: `done_o` and `err_o` hold their values until reset or the next start pulse. A start pulse given in the done or error state restarts the sequence and clears both flags in the cycle after the start edge.
- R11: Changes to the memory-type, CAS or gap inputs after the start edge do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches the sequence |
| ddr2_sel_i | input | 1 | 0 = DDR1 device, 1 = DDR2 device |
| cas_code_i | input | 3 | CAS-latency code for A6:A4 |
| t_mrd_i | input | WAIT_W | Gap after each mode-register-set, in cycles |
| t_rp_i | input | WAIT_W | Gap after precharge-all, in cycles |
| t_rfc_i | input | WAIT_W | Gap after each auto-refresh, in cycles |
| cmd_o | output | 2 | Command code (NOP/PRE/REF/MRS) |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus A12..A0 |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Illegal CAS/type pairing; final write withheld |

## Verification
The hardest situations to reach are the ones where the design must ignore its inputs while busy: a second start pulse, or new gap and CAS values arriving partway through the gaps. The stimulus covers this with a sequence that has long gaps. Partway through it, the bench pulses start again and rewrites every configuration input. The reference model, which captured the values at the original start edge, then predicts the exact cycle of every later command. Back-to-back issue is forced by programming all gaps to 0. Illegal pairings for both memory types are run and are followed by a restart from the error state.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_PRE = 2'b01,
        CMD_REF = 2'b10,
        CMD_MRS = 2'b11
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EMR,
        ST_MRS_DLL,
        ST_PRE,
        ST_REF1,
        ST_REF2,
        ST_MRS_FIN,
        ST_DONE,
        ST_ERR
    } step_e;

    typedef enum logic [1:0] {
        WORD_EMR,
        WORD_MRS_DLL,
        WORD_MRS_RUN,
        WORD_PRE
    } word_e;

endpackage

// File: rtl/ddr_init_cas_legal.sv
module ddr_init_cas_legal (
    input  logic       ddr2_i,
    input  logic [2:0] cas_i,
    output logic       legal_o
);
    always_comb begin
        unique case (cas_i)
            3'b010, 3'b110: legal_o = !ddr2_i;
            3'b011, 3'b100: legal_o = ddr2_i;
            default:        legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ddr_init_mode_word.sv
module ddr_init_mode_word
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  word_e             kind_i,
    input  logic [2:0]        cas_i,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CL_LSB  = 4;
    localparam int OPM_LSB = 7;
    localparam int AP_BIT  = 10;

    always_comb begin
        ba_o   = '0;
        addr_o = '0;
        unique case (kind_i)
            WORD_EMR: ba_o = BA_W'(1);
            WORD_PRE: addr_o[AP_BIT] = 1'b1;
            WORD_MRS_DLL, WORD_MRS_RUN: begin
                addr_o[BL_LSB +: 3]  = 3'b010;
                addr_o[BT_BIT]       = 1'b0;
                addr_o[CL_LSB +: 3]  = cas_i;
                addr_o[OPM_LSB +: 2] = (kind_i == WORD_MRS_DLL) ? 2'b10 : 2'b00;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int WAIT_W = 8,
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              ddr2_sel_i,
    input  logic [2:0]        cas_code_i,
    input  logic [WAIT_W-1:0] t_mrd_i,
    input  logic [WAIT_W-1:0] t_rp_i,
    input  logic [WAIT_W-1:0] t_rfc_i,
    output logic [1:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        step_e             st;
        logic [WAIT_W-1:0] cnt;
        cmd_e              cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              err;
        logic              ddr2;
        logic [2:0]        cas;
        logic [WAIT_W-1:0] t_mrd;
        logic [WAIT_W-1:0] t_rp;
        logic [WAIT_W-1:0] t_rfc;
    } seq_t;

    seq_t q_q, n_d;

    word_e             word_kind;
    logic [BA_W-1:0]   word_ba;
    logic [ADDR_W-1:0] word_addr;
    logic              cas_ok;
    logic              busy;

    function automatic logic [WAIT_W-1:0] gap_load(input logic [WAIT_W-1:0] t);
        return (t == '0) ? '0 : t - 1'b1;
    endfunction

    always_comb begin
        unique case (q_q.st)
            ST_EMR:     word_kind = WORD_EMR;
            ST_MRS_DLL: word_kind = WORD_MRS_DLL;
            ST_PRE:     word_kind = WORD_PRE;
            default:    word_kind = WORD_MRS_RUN;
        endcase
    end

    ddr_init_mode_word #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_word (
        .kind_i (word_kind),
        .cas_i  (q_q.cas),
        .ba_o   (word_ba),
        .addr_o (word_addr)
    );

    ddr_init_cas_legal u_legal (
        .ddr2_i  (q_q.ddr2),
        .cas_i   (q_q.cas),
        .legal_o (cas_ok)
    );

    assign busy = (q_q.st != ST_IDLE) && (q_q.st != ST_DONE) && (q_q.st != ST_ERR);

    always_comb begin
        n_d      = q_q;
        n_d.cmd  = CMD_NOP;
        n_d.ba   = '0;
        n_d.addr = '0;
        if (!busy) begin
            if (start_i) begin
                n_d.st    = ST_EMR;
                n_d.cnt   = '0;
                n_d.done  = 1'b0;
                n_d.err   = 1'b0;
                n_d.ddr2  = ddr2_sel_i;
                n_d.cas   = cas_code_i;
                n_d.t_mrd = t_mrd_i;
                n_d.t_rp  = t_rp_i;
                n_d.t_rfc = t_rfc_i;
            end
        end else if (q_q.cnt != '0) begin
            n_d.cnt = q_q.cnt - 1'b1;
        end else begin
            unique case (q_q.st)
                ST_EMR: begin
                    n_d.cmd  = CMD_MRS;
                    n_d.ba   = word_ba;
                    n_d.addr = word_addr;
                    n_d.cnt  = gap_load(q_q.t_mrd);
                    n_d.st   = ST_MRS_DLL;
                end
                ST_MRS_DLL: begin
                    n_d.cmd  = CMD_MRS;
                    n_d.ba   = word_ba;
                    n_d.addr = word_addr;
                    n_d.cnt  = gap_load(q_q.t_mrd);
                    n_d.st   = ST_PRE;
                end
                ST_PRE: begin
                    n_d.cmd  = CMD_PRE;
                    n_d.ba   = word_ba;
                    n_d.addr = word_addr;
                    n_d.cnt  = gap_load(q_q.t_rp);
                    n_d.st   = ST_REF1;
                end
                ST_REF1: begin
                    n_d.cmd = CMD_REF;
                    n_d.cnt = gap_load(q_q.t_rfc);
                    n_d.st  = ST_REF2;
                end
                ST_REF2: begin
                    n_d.cmd = CMD_REF;
                    n_d.cnt = gap_load(q_q.t_rfc);
                    n_d.st  = ST_MRS_FIN;
                end
                ST_MRS_FIN: begin
                    if (cas_ok) begin
                        n_d.cmd  = CMD_MRS;
                        n_d.ba   = word_ba;
                        n_d.addr = word_addr;
                        n_d.done = 1'b1;
                        n_d.st   = ST_DONE;
                    end else begin
                        n_d.err = 1'b1;
                        n_d.st  = ST_ERR;
                    end
                end
                default: n_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q      <= '0;
            q_q.st   <= ST_IDLE;
            q_q.cmd  <= CMD_NOP;
        end else begin
            q_q <= n_d;
        end
    end

    assign cmd_o  = q_q.cmd;
    assign ba_o   = q_q.ba;
    assign addr_o = q_q.addr;
    assign done_o = q_q.done;
    assign err_o  = q_q.err;

    AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_NOP) |-> (ba_o == '0 && addr_o == '0)); // R2
    AST_MRS_A12_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_MRS) |-> !addr_o[12]); // R4
    AST_GAP_IS_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && q_q.cnt != '0) |=> (cmd_o == CMD_NOP)); // R6
    AST_DONE_WITH_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (cmd_o == CMD_MRS && addr_o[8:7] == 2'b00)); // R5
    AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o)); // R7
    AST_ERR_NO_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> (cmd_o == CMD_NOP)); // R7
    AST_PRE_A10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_PRE) |-> (addr_o[10] && ba_o == '0)); // R8
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && start_i && q_q.cnt != '0) |=> (q_q.st == $past(q_q.st))); // R9
endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb_top;
    localparam int WAIT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              ddr2 = 1'b0;
    logic [2:0]        cas = 3'b010;
    logic [WAIT_W-1:0] t_mrd = '0;
    logic [WAIT_W-1:0] t_rp = '0;
    logic [WAIT_W-1:0] t_rfc = '0;
    logic [1:0]        cmd;
    logic [1:0]        ba;
    logic [12:0]       addr;
    logic              done;
    logic              err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string scen = "R1";
    bit finished = 0;

    always #10 clk = ~clk;

    ddr_init_seq #(.WAIT_W(WAIT_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ddr2_sel_i(ddr2),
        .cas_code_i(cas), .t_mrd_i(t_mrd), .t_rp_i(t_rp), .t_rfc_i(t_rfc),
        .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .done_o(done), .err_o(err)
    );

    typedef struct {
        logic [1:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        done;
        logic        err;
        int          tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    bit   cur_valid = 0;
    logic hold_done = 0, hold_err = 0;

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";  3: return "R3";  4: return "R4";  5: return "R5";
            6: return "R6";  7: return "R7";  8: return "R8";  default: return "R10";
        endcase
    endfunction

    function automatic void push(input logic [1:0] c, input logic [1:0] b,
                                 input logic [12:0] a, input logic dn,
                                 input logic er, input int t);
        exp_t e;
        e.cmd = c; e.ba = b; e.addr = a; e.done = dn; e.err = er; e.tag = t;
        exp_q.push_back(e);
    endfunction

    function automatic void gap(input int w);
        for (int i = 1; i < w; i++) push(2'b00, 2'b00, 13'h0, 1'b0, 1'b0, 6);
    endfunction

    function automatic void build(input logic d2, input logic [2:0] c,
                                  input int m, input int p, input int f);
        int wm = (m == 0) ? 1 : m;
        int wp = (p == 0) ? 1 : p;
        int wf = (f == 0) ? 1 : f;
        bit ok = d2 ? (c == 3'b011 || c == 3'b100) : (c == 3'b010 || c == 3'b110);
        push(2'b11, 2'b01, 13'h0, 1'b0, 1'b0, 3);                          gap(wm);
        push(2'b11, 2'b00, {4'b0, 2'b10, c, 1'b0, 3'b010}, 1'b0, 1'b0, 4); gap(wm);
        push(2'b01, 2'b00, 13'h400, 1'b0, 1'b0, 8);                        gap(wp);
        push(2'b10, 2'b00, 13'h0, 1'b0, 1'b0, 8);                          gap(wf);
        push(2'b10, 2'b00, 13'h0, 1'b0, 1'b0, 8);                          gap(wf);
        if (ok) push(2'b11, 2'b00, {4'b0, 2'b00, c, 1'b0, 3'b010}, 1'b1, 1'b0, 5);
        else    push(2'b00, 2'b00, 13'h0, 1'b0, 1'b1, 7);
    endfunction

    // Behavioural reference: one expected output word per clock
    always @(posedge clk) begin
        cur_valid <= 1;
        if (!rst_n) begin
            exp_q.delete();
            hold_done = 0; hold_err = 0;
            cur = '{2'b00, 2'b00, 13'h0, 1'b0, 1'b0, 1};
        end else if (exp_q.size() == 0) begin
            cur = '{2'b00, 2'b00, 13'h0, hold_done, hold_err, 10};
            if (start) begin
                cur.done = 0; cur.err = 0; hold_done = 0; hold_err = 0;
                build(ddr2, cas, int'(t_mrd), int'(t_rp), int'(t_rfc));
            end
        end else begin
            cur = exp_q.pop_front();
            hold_done = cur.done; hold_err = cur.err;
        end
    end

    always @(negedge clk) begin
        if (cur_valid && !finished) begin
            checks++;
            if (cmd !== cur.cmd) begin
                failures++;
                $display("FAIL %s/R2 (scenario %s) cycle %0d cmd actual=%b expected=%b",
                         tag_name(cur.tag), scen, cyc, cmd, cur.cmd);
            end
            checks++;
            if (ba !== cur.ba || addr !== cur.addr) begin
                failures++;
                $display("FAIL %s (scenario %s) cycle %0d ba/addr actual=%b/%h expected=%b/%h",
                         tag_name(cur.tag), scen, cyc, ba, addr, cur.ba, cur.addr);
            end
            checks++;
            if (done !== cur.done || err !== cur.err) begin
                failures++;
                $display("FAIL %s (scenario %s) cycle %0d done/err actual=%b/%b expected=%b/%b",
                         tag_name(cur.tag), scen, cyc, done, err, cur.done, cur.err);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic pulse_start;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic d2, input logic [2:0] c,
                       input int m, input int p, input int f);
        @(negedge clk);
        ddr2 = d2; cas = c;
        t_mrd = WAIT_W'(m); t_rp = WAIT_W'(p); t_rfc = WAIT_W'(f);
        pulse_start();
    endtask

    task automatic drain;
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        scen = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        scen = "R2";   run(1'b0, 3'b010, 2, 3, 4);  drain();
        scen = "R10";  repeat (4) @(negedge clk);
        scen = "R6";   run(1'b1, 3'b100, 0, 0, 0);  drain();
        scen = "R6b";  run(1'b1, 3'b011, 1, 5, 7);  drain();

        scen = "R9";
        run(1'b0, 3'b110, 6, 9, 12);
        repeat (5) @(negedge clk);
        ddr2 = 1'b1; cas = 3'b111; t_mrd = 8'd1; t_rp = 8'd1; t_rfc = 8'd1;
        pulse_start();
        scen = "R11";
        repeat (20) @(negedge clk);
        pulse_start();
        drain();

        scen = "R7";   run(1'b1, 3'b110, 2, 2, 3);  drain();
        scen = "R7b";  run(1'b0, 3'b011, 1, 1, 1);  drain();
        scen = "R7c";  run(1'b0, 3'b000, 3, 1, 2);  drain();
        scen = "R10b"; repeat (3) @(negedge clk);
        run(1'b0, 3'b110, 255, 4, 3);  drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule